// File: doc/BRIEF.md
# Expansion Slot Register Decoder

This block is the register front end of a plug-in card that sits on a 16-bit host bus with a 20-bit demultiplexed address. The host gives each slot its own active-low I/O chip-select that covers a 16-word local window. The block watches that select along with the low latched address bits, the byte-high enable, the read and write strobes and the address latch pulse. Address bit 4 splits the window into two independent virtual modules. Each virtual module has a read-only identification byte and fifteen general-purpose byte registers.

All bus inputs are sampled on the block clock. A register access happens once per bus cycle. The latch pulse arms an access, and the first falling edge of a strobe that follows it, while the select is low, commits the access and disarms it. An interrupt-acknowledge cycle pulses the latch but never drives a strobe, so it reaches no register. A late glitch on a strobe finds the block disarmed and does nothing.

The block drives read data only when the bus data enable and the direction control are both low. The open-drain wait request is modelled as a pull-low enable. It is raised when the select falls, so that the host inserts wait states, and it is dropped after a set number of clocks or as soon as the select returns high. The bus has no valid/ready stream: every pin is a plain control or data level.

Top module: `slot_regs_top`

## Requirements
- R1: While `sel_n` is high the block ignores strobes: writes change no register and `data_oe` stays 0.
- R2: Address bit 4 picks the virtual module (0 or 1). Each module owns 8 word locations, with the word index taken from address bits 3..1.
- R3: On a write, the low byte (`data_in[7:0]`) is written when address bit 0 is 0, and the high byte (`data_in[15:8]`) is written when `bhe_n` is 0. Both conditions together write the whole word. When address bit 0 is 1 and `bhe_n` is 1, nothing is written. A read returns both bytes of the addressed word, with the higher-numbered byte on `data_out[15:8]`.
- R4: The low byte of word 0 in each virtual module is its identification byte. It always reads as that module's code, and writes to it are ignored. The high byte of word 0 is a normal register.
- R5: A virtual module whose bit in `FITTED` is 0 reads as 16'h0000 at every word, including its identification byte, and ignores all writes.
- R6: A cycle that pulses `ale` with the select low but drives neither strobe (interrupt acknowledge) writes nothing and never raises `data_oe`, even while `den_n` and `dtr_n` are low.
- R7: At most one access is committed per `ale` pulse. A second falling edge of either strobe before the next `ale` has no effect.
- R8: `data_oe` is 1 only when a read has been committed in the current cycle and `den_n` and `dtr_n` are both 0. `data_out` is 16'h0000 whenever `data_oe` is 0.
- R9: `wait_oe` is 1 from the moment `sel_n` goes low until `WAIT_CYCLES` clock edges have sampled `sel_n` low. It is 0 whenever `sel_n` is high.
- R10: A synchronous active-low `rst_n` clears every general-purpose register to zero. The identification bytes are unaffected.
- R11: A read committed at a clock edge drives its data from that edge until the select goes high. A write committed at an edge is seen by any later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (fed by the sleep line) |
| sel_n | input | 1 | Active-low per-slot I/O chip-select |
| ale | input | 1 | Address latch pulse; marks the start of a bus cycle |
| addr | input | 5 | Latched address bits 4..0 |
| bhe_n | input | 1 | Active-low byte-high enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| den_n | input | 1 | Active-low data buffer enable |
| dtr_n | input | 1 | Direction control; low means the card drives the host |
| data_in | input | 16 | Write data from the host |
| data_out | output | 16 | Read data toward the host |
| data_oe | output | 1 | Output enable for `data_out` |
| wait_oe | output | 1 | When 1, pull the open-drain READY line low |

## Verification
A strobe that goes low before rising edge P is committed at P. For a read, `data_oe` and `data_out` are therefore valid from the falling edge after P, and the bench samples them at that falling edge. A write lands at P and is checked through a later full read cycle. `wait_oe` depends combinationally on `sel_n` and on a counter that counts rising edges with the select low. The bench samples it one time unit after changing `sel_n` and then on each falling edge, expecting the count to reach `WAIT_CYCLES` after that many rising edges. Every input is driven on a falling edge, so no sample falls on an active edge.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int unsigned VM_COUNT  = 2;
  localparam int unsigned VM_WORDS  = 8;
  localparam int unsigned WORD_W    = $clog2(VM_WORDS);
  localparam int unsigned ADDR_W    = WORD_W + 2;

  typedef struct packed {
    logic              vm;
    logic [WORD_W-1:0] word;
    logic              lane_lo;
    logic              lane_hi;
  } slot_sel_t;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import slot_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bhe_n,
  output slot_sel_t         sel
);
  always_comb begin
    sel.vm      = addr[ADDR_W-1];
    sel.word    = addr[ADDR_W-2:1];
    sel.lane_lo = ~addr[0];
    sel.lane_hi = ~bhe_n;
  end
endmodule

// File: rtl/slot_vmod.sv
module slot_vmod
  import slot_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h00,
  parameter bit         FITTED  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  input  logic              lane_lo,
  input  logic              lane_hi,
  input  logic [15:0]       wdata,
  output logic [15:0]       rword
);
  localparam int unsigned NBYTES = 2 * VM_WORDS;

  generate
    if (FITTED) begin : g_fitted
      logic [NBYTES-1:0][7:0] bank;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bank <= '0;
        end else if (we) begin
          if (lane_lo && (word != '0)) bank[{word, 1'b0}] <= wdata[7:0];
          if (lane_hi)                 bank[{word, 1'b1}] <= wdata[15:8];
        end
      end

      always_comb begin
        rword[15:8] = bank[{word, 1'b1}];
        rword[7:0]  = (word == '0) ? ID_CODE : bank[{word, 1'b0}];
      end

      // R10 / R1: registers change only on a committed write
      a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank));
    end else begin : g_absent
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, we, word, lane_lo, lane_hi, wdata};
      assign rword = '0;
    end
  endgenerate
endmodule

// File: rtl/slot_wait.sv
module slot_wait #(
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic wait_oe
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || sel_n) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign wait_oe = !sel_n && (cnt != CNT_MAX);

  // R9: a freshly asserted select always starts with the wait request raised
  a_r9_wait_on_new_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $past(sel_n)) |-> wait_oe);
endmodule

// File: rtl/slot_regs_top.sv
module slot_regs_top
  import slot_pkg::*;
#(
  parameter logic [7:0]          ID_VM0      = 8'h51,
  parameter logic [7:0]          ID_VM1      = 8'h52,
  parameter logic [VM_COUNT-1:0] FITTED      = '1,
  parameter int unsigned         WAIT_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        ale,
  input  logic [4:0]  addr,
  input  logic        bhe_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        den_n,
  input  logic        dtr_n,
  input  logic [15:0] data_in,
  output logic [15:0] data_out,
  output logic        data_oe,
  output logic        wait_oe
);
  slot_sel_t sel;
  logic      rd_prev, wr_prev, armed, rd_hit;
  logic      go_rd, go_wr;
  logic [15:0] rdata_q;
  logic [VM_COUNT-1:0]       vm_we;
  logic [VM_COUNT-1:0][15:0] vm_word;

  slot_decode u_dec (.addr(addr[ADDR_W-1:0]), .bhe_n(bhe_n), .sel(sel));

  // A strobe commits only on its first falling edge after an ale pulse
  assign go_rd = armed && !ale && !sel_n && rd_prev && !rd_n;
  assign go_wr = armed && !ale && !sel_n && wr_prev && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
      armed   <= 1'b0;
      rd_hit  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_prev <= rd_n;
      wr_prev <= wr_n;
      if (ale)                armed <= 1'b1;
      else if (go_rd || go_wr) armed <= 1'b0;
      if (ale || sel_n)       rd_hit <= 1'b0;
      else if (go_rd)         rd_hit <= 1'b1;
      if (go_rd)              rdata_q <= vm_word[sel.vm];
    end
  end

  generate
    for (genvar v = 0; v < VM_COUNT; v++) begin : g_vm
      assign vm_we[v] = go_wr && (sel.vm == v[0]);
      slot_vmod #(
        .ID_CODE (v == 0 ? ID_VM0 : ID_VM1),
        .FITTED  (FITTED[v])
      ) u_vm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (vm_we[v]),
        .word    (sel.word),
        .lane_lo (sel.lane_lo),
        .lane_hi (sel.lane_hi),
        .wdata   (data_in),
        .rword   (vm_word[v])
      );
    end
  endgenerate

  assign data_oe  = rd_hit && !den_n && !dtr_n;
  assign data_out = data_oe ? rdata_q : '0;

  slot_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wait_oe(wait_oe));

  // R2: a write reaches at most one virtual module
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vm_we));
  // R7: no two commits in a row without a fresh latch pulse
  a_r7_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd || go_wr) |=> !(go_rd || go_wr));
  // R8: the bus is driven only under the host's enable and direction
  a_r8_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!den_n && !dtr_n && !sel_n));
endmodule

// File: tb/slot_regs_top_tb_top.sv
module slot_regs_top_tb_top;
  localparam logic [7:0] ID0 = 8'hA5;
  localparam logic [7:0] ID1 = 8'h3C;
  localparam int unsigned WAITS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, ale = 1'b0, bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic den_n = 1'b1, dtr_n = 1'b1;
  logic [4:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic data_oe, wait_oe;
  int total = 0, bad = 0, cycles = 0;
  logic [7:0] m [0:1][0:15];

  always #10 clk = ~clk;

  slot_regs_top #(.ID_VM0(ID0), .ID_VM1(ID1), .FITTED(2'b01), .WAIT_CYCLES(WAITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ale(ale), .addr(addr), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr_n(dtr_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .wait_oe(wait_oe));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input int vm, input int w);
    if (vm != 0) return 16'h0000;
    return {m[0][2*w+1], (w == 0) ? ID0 : m[0][2*w]};
  endfunction

  // One bus cycle; sel_v=1 drives the select low
  task automatic cyc(input bit wr, input bit sel_v, input logic [4:0] a, input bit bhe,
                     input logic [15:0] wd, output logic [15:0] rd, output logic oe);
    @(negedge clk) sel_n = !sel_v; ale = 1'b1; addr = a; bhe_n = bhe;
    @(negedge clk) ale = 1'b0;
    @(negedge clk)
      if (wr) begin data_in = wd; wr_n = 1'b0; end
      else begin rd_n = 1'b0; den_n = 1'b0; dtr_n = 1'b0; end
    @(negedge clk) rd = data_out; oe = data_oe;
    @(negedge clk) rd_n = 1'b1; wr_n = 1'b1; den_n = 1'b1; dtr_n = 1'b1; sel_n = 1'b1;
  endtask

  task automatic model_write(input int vm, input int w, input bit lo, input bit hi,
                             input logic [15:0] wd);
    if (vm == 0) begin
      if (lo && w != 0) m[0][2*w] = wd[7:0];
      if (hi) m[0][2*w+1] = wd[15:8];
    end
  endtask

  initial begin
    logic [15:0] rd;
    logic oe;
    for (int v = 0; v < 2; v++) for (int b = 0; b < 16; b++) m[v][b] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset data_oe", {15'd0, data_oe}, 16'h0000);
    check("R9 idle wait_oe", {15'd0, wait_oe}, 16'h0000);

    cyc(0, 1, 5'b00000, 1'b0, 16'h0, rd, oe);
    check("R4 id vm0 read", rd, {8'h00, ID0});
    check("R8 read drives oe", {15'd0, oe}, 16'h0001);
    cyc(0, 1, 5'b10000, 1'b0, 16'h0, rd, oe);
    check("R5 unfitted id reads zero", rd, 16'h0000);

    cyc(1, 1, 5'b00000, 1'b0, 16'h77FF, rd, oe);
    model_write(0, 0, 1'b1, 1'b1, 16'h77FF);
    cyc(0, 1, 5'b00000, 1'b0, 16'h0, rd, oe);
    check("R4 id write ignored", rd, expect_word(0, 0));

    // R2 R3 R11: sweep every module, word and lane pattern
    for (int vm = 0; vm < 2; vm++)
      for (int w = 0; w < 8; w++)
        for (int md = 0; md < 4; md++) begin
          logic [15:0] wd;
          logic a0, bh;
          wd = 16'((vm * 32 + w * 4 + md + 1) * 16'h2F1B);
          a0 = (md == 1 || md == 3);
          bh = (md == 0 || md == 3);
          cyc(1, 1, {vm[0], w[2:0], a0}, bh, wd, rd, oe);
          model_write(vm, w, !a0, !bh, wd);
          cyc(0, 1, {vm[0], w[2:0], 1'b0}, 1'b0, 16'h0, rd, oe);
          check(vm == 0 ? "R3 R11 lane write readback" : "R5 R2 unfitted write ignored",
                rd, expect_word(vm, w));
        end
    for (int vm = 0; vm < 2; vm++)
      for (int w = 0; w < 8; w++) begin
        cyc(0, 1, {vm[0], w[2:0], 1'b1}, 1'b1, 16'h0, rd, oe);
        check("R2 full sweep readback", rd, expect_word(vm, w));
      end

    // R1: strobes with select high
    cyc(1, 0, 5'b00010, 1'b0, 16'hDEAD, rd, oe);
    cyc(0, 0, 5'b00010, 1'b0, 16'h0, rd, oe);
    check("R1 no drive without select", {15'd0, oe}, 16'h0000);
    cyc(0, 1, 5'b00010, 1'b0, 16'h0, rd, oe);
    check("R1 write without select ignored", rd, expect_word(0, 1));

    // R6: interrupt acknowledge
    @(negedge clk) sel_n = 1'b0; ale = 1'b1; addr = 5'b00100; bhe_n = 1'b0; data_in = 16'hBEEF;
    @(negedge clk) ale = 1'b0; den_n = 1'b0; dtr_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 int-ack no drive", {15'd0, data_oe}, 16'h0000);
    end
    @(negedge clk) den_n = 1'b1; dtr_n = 1'b1; sel_n = 1'b1;
    cyc(0, 1, 5'b00100, 1'b0, 16'h0, rd, oe);
    check("R6 int-ack no write", rd, expect_word(0, 2));

    // R7: second write strobe in the same cycle
    @(negedge clk) sel_n = 1'b0; ale = 1'b1; addr = 5'b00110; bhe_n = 1'b0;
    @(negedge clk) ale = 1'b0;
    @(negedge clk) data_in = 16'h1234; wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) data_in = 16'h9876; wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1; rd_n = 1'b0; den_n = 1'b0; dtr_n = 1'b0;
    @(negedge clk) check("R7 unarmed read no drive", {15'd0, data_oe}, 16'h0000);
    rd_n = 1'b1; den_n = 1'b1; dtr_n = 1'b1; sel_n = 1'b1;
    model_write(0, 3, 1'b1, 1'b1, 16'h1234);
    cyc(0, 1, 5'b00110, 1'b0, 16'h0, rd, oe);
    check("R7 glitch write ignored", rd, expect_word(0, 3));

    // R7 R8: read glitch after the cycle ends
    @(negedge clk) rd_n = 1'b0; den_n = 1'b0; dtr_n = 1'b0;
    @(negedge clk) check("R7 late read glitch no drive", {15'd0, data_oe}, 16'h0000);
    check("R8 data zero when idle", data_out, 16'h0000);
    rd_n = 1'b1; den_n = 1'b1; dtr_n = 1'b1;

    // R8: enable gating
    @(negedge clk) sel_n = 1'b0; ale = 1'b1; addr = 5'b00110; bhe_n = 1'b0;
    @(negedge clk) ale = 1'b0;
    @(negedge clk) rd_n = 1'b0; dtr_n = 1'b0;
    @(negedge clk) check("R8 den high no drive", {15'd0, data_oe}, 16'h0000);
    check("R8 den high data zero", data_out, 16'h0000);
    den_n = 1'b0;
    #1 check("R8 den low drives", data_out, expect_word(0, 3));
    @(negedge clk) rd_n = 1'b1; den_n = 1'b1; dtr_n = 1'b1; sel_n = 1'b1;

    // R9: wait request window
    @(negedge clk) sel_n = 1'b0;
    #1 check("R9 wait on select", {15'd0, wait_oe}, 16'h0001);
    for (int k = 1; k <= int'(WAITS); k++) begin
      @(negedge clk);
      check("R9 wait count", {15'd0, wait_oe}, (k == int'(WAITS)) ? 16'h0000 : 16'h0001);
    end
    @(negedge clk) sel_n = 1'b1;
    @(negedge clk) sel_n = 1'b0;
    @(negedge clk);
    check("R9 wait restarts", {15'd0, wait_oe}, 16'h0001);
    sel_n = 1'b1;
    #1 check("R9 release on select high", {15'd0, wait_oe}, 16'h0000);

    // R10: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int v = 0; v < 2; v++) for (int b = 0; b < 16; b++) m[v][b] = 8'h00;
    cyc(0, 1, 5'b00110, 1'b0, 16'h0, rd, oe);
    check("R10 reset clears register", rd, 16'h0000);
    cyc(0, 1, 5'b00000, 1'b0, 16'h0, rd, oe);
    check("R10 id survives reset", rd, {8'h00, ID0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule